// File: doc/BRIEF.md
# Event Routing Channel Array

This block routes hardware events between on-chip producers and consumers through twelve independent channels. Each channel has a control register that selects one line from a bank of producer signals. The bank is addressed by a source number and a signal number within that source. An optional edge stage can turn the selected level into one-clock pulses. Software can add a persistent level and a one-clock pulse on top of the hardware contribution.

The channel outputs feed event consumers directly. A routing register gates the first four channels onto pin outputs. It also carries a location code that the pin multiplexer outside the block decodes.

All configuration sits behind a plain 32-bit write bus with a combinational read port. The block has no handshake: a write takes effect at the clock edge where `wr_en` is high.

Top module: `evt_router`

## Requirements
- R1: After reset every register reads zero, and `chan_out`, `pin_out` and `pin_loc` are all zero.
- R2: The channel n control word sits at byte address 0x10+4n. Signal select is bits 2:0, source select bits 21:16, edge mode bits 25:24 and the direct (asynchronous) flag bit 28. Writing all ones reads back 0x133F0007.
- R3: A channel whose source select is 0 contributes a low hardware signal, whatever the producer bank carries.
- R4: With a nonzero source s and signal g in edge mode 0, the hardware signal is `prod_in[s*8+g]`. It follows that input in the same cycle.
- R5: Edge mode 1 gives a high hardware signal for exactly the one cycle in which the selected input is high and was low at the previous clock edge. Falling transitions give nothing.
- R6: Edge mode 2 gives a one-cycle pulse on each high-to-low transition of the selected input, and nothing on rising transitions.
- R7: Edge mode 3 gives a one-cycle pulse on every transition of the selected input.
- R8: When the direct flag is set, the edge stage is bypassed and the selected input drives the hardware signal as a level, whatever the edge mode.
- R9: Writing to address 0x0 sets a pulse, for exactly the one cycle after the write edge, on each channel whose bit (bits 11:0) is 1. Address 0x0 always reads zero.
- R10: Address 0x4 holds one software level bit per channel in bits 11:0. It reads back only those bits.
- R11: Address 0x8 holds pin enables for channels 0 to 3 in bits 3:0 and a 3-bit location code in bits 10:8. `pin_out[k]` equals `chan_out[k]` when its enable is set and is 0 otherwise. `pin_loc` shows the stored code.
- R12: Each channel output is the XOR of its hardware signal, its software level bit and its software pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 10 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| prod_in | input | 512 | Producer bank, bit s*8+g is signal g of source s |
| chan_out | output | 12 | Channel event outputs |
| pin_out | output | 4 | Gated outputs of channels 0 to 3 |
| pin_loc | output | 3 | Stored pin location code |

## Verification
The channel outputs are combinational from `prod_in`, so a producer change shows in the same cycle. The edge modes compare that change against the sample taken at the last rising edge. A register write changes outputs and read data from the rising edge on which `wr_en` was high. A software pulse is visible only between that edge and the next. The bench drives every input at the falling edge and samples 1 ns later. This places each check inside the cycle in which the result is due and away from any edge. The bench keeps a shadow of the configuration and of the previous samples, updated at the edges the requirements name, and compares the whole output vector against it on every random cycle.

// File: rtl/evt_router.sv
module evt_router #(
  parameter int NCH  = 12,
  parameter int NSRC = 64,
  parameter int NSIG = 8,
  parameter int NPIN = 4,
  parameter int AW   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [NSRC*NSIG-1:0] prod_in,
  output logic [NCH-1:0]       chan_out,
  output logic [NPIN-1:0]      pin_out,
  output logic [2:0]           pin_loc
);
  localparam int SRCW = $clog2(NSRC);
  localparam int SIGW = $clog2(NSIG);
  localparam int CTRL_BASE = 4;

  logic [NCH-1:0][SIGW-1:0] sig_q;
  logic [NCH-1:0][SRCW-1:0] src_q;
  logic [NCH-1:0][1:0]      mode_q;
  logic [NCH-1:0]           async_q, level_q, pulse_q, prev_q;
  logic [NCH-1:0]           sel, hw;
  logic [NPIN-1:0]          pen_q;
  logic [2:0]               loc_q;
  int                       widx;

  assign widx = int'(addr[AW-1:2]);

  always_comb begin
    for (int i = 0; i < NCH; i++)
      sel[i] = (src_q[i] == '0) ? 1'b0 : prod_in[{src_q[i], sig_q[i]}];
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      case (mode_q[i])
        2'd0:    hw[i] = sel[i];
        2'd1:    hw[i] = sel[i] & ~prev_q[i];
        2'd2:    hw[i] = ~sel[i] & prev_q[i];
        default: hw[i] = sel[i] ^ prev_q[i];
      endcase
      if (async_q[i]) hw[i] = sel[i];
    end
  end

  assign chan_out = hw ^ level_q ^ pulse_q;
  assign pin_out  = chan_out[NPIN-1:0] & pen_q;
  assign pin_loc  = loc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_q   <= '0;
      src_q   <= '0;
      mode_q  <= '0;
      async_q <= '0;
      level_q <= '0;
      pulse_q <= '0;
      prev_q  <= '0;
      pen_q   <= '0;
      loc_q   <= '0;
    end else begin
      prev_q  <= sel;
      pulse_q <= (wr_en && widx == 0) ? wdata[NCH-1:0] : '0;
      if (wr_en && widx == 1) level_q <= wdata[NCH-1:0];
      if (wr_en && widx == 2) begin
        pen_q <= wdata[NPIN-1:0];
        loc_q <= wdata[10:8];
      end
      for (int i = 0; i < NCH; i++) begin
        if (wr_en && widx == CTRL_BASE + i) begin
          sig_q[i]   <= wdata[SIGW-1:0];
          src_q[i]   <= wdata[16 +: SRCW];
          mode_q[i]  <= wdata[25:24];
          async_q[i] <= wdata[28];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (widx == 1) rdata[NCH-1:0] = level_q;
    if (widx == 2) begin
      rdata[NPIN-1:0] = pen_q;
      rdata[10:8]     = loc_q;
    end
    for (int i = 0; i < NCH; i++) begin
      if (widx == CTRL_BASE + i) begin
        rdata[SIGW-1:0]   = sig_q[i];
        rdata[16 +: SRCW] = src_q[i];
        rdata[25:24]      = mode_q[i];
        rdata[28]         = async_q[i];
      end
    end
  end

  wire unused_bits = ^{wdata, addr[1:0]};
endmodule

module evt_router_chk #(
  parameter int NCH  = 12,
  parameter int NPIN = 4,
  parameter int AW   = 10,
  parameter int SRCW = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [AW-1:0]             addr,
  input logic [31:0]               rdata,
  input logic [NCH-1:0]            chan_out,
  input logic [NPIN-1:0]           pin_out,
  input logic [2:0]                pin_loc,
  input logic [NCH-1:0][SRCW-1:0]  src_q,
  input logic [NCH-1:0][1:0]       mode_q,
  input logic [NCH-1:0]            async_q,
  input logic [NCH-1:0]            level_q,
  input logic [NCH-1:0]            pulse_q
);
  a_r9_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    addr[AW-1:2] == '0 |-> rdata == 32'd0);

  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && addr[AW-1:2] == '0) |-> pulse_q == '0);

  a_r11_loc_readback: assert property (@(posedge clk) disable iff (!rst_n)
    addr[AW-1:2] == 2 |-> rdata[10:8] == pin_loc);

  a_r11_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~chan_out[NPIN-1:0]) == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    a_r3_no_source: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q[i] == '0 && !level_q[i] && !pulse_q[i]) |-> !chan_out[i]);

    a_r5_edge_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q[i] == 2'd1 || mode_q[i] == 2'd2) && !async_q[i] && !level_q[i]
       && !pulse_q[i] && chan_out[i] && !wr_en) |=> !chan_out[i]);
  end
endmodule

bind evt_router evt_router_chk #(.NCH(NCH), .NPIN(NPIN), .AW(AW), .SRCW(SRCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .chan_out(chan_out), .pin_out(pin_out), .pin_loc(pin_loc),
  .src_q(src_q), .mode_q(mode_q), .async_q(async_q),
  .level_q(level_q), .pulse_q(pulse_q)
);

// File: tb/evt_router_tb.sv
`timescale 1ns/1ps
module evt_router_tb;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         wr_en = 0;
  logic [9:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [511:0] prod = '0;
  logic [11:0]  chan_out;
  logic [3:0]   pin_out;
  logic [2:0]   pin_loc;

  int nchk = 0, nerr = 0;
  int sh_src[12], sh_sig[12], sh_mode[12], sh_async[12];
  logic [11:0] sh_level = '0, pulse_exp = '0, mprev = '0;
  logic [3:0]  sh_pen = '0;
  logic [2:0]  sh_loc = '0;

  always #5 clk = ~clk;

  evt_router u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .prod_in(prod), .chan_out(chan_out),
    .pin_out(pin_out), .pin_loc(pin_loc));

  function automatic logic model_sel(int n);
    return (sh_src[n] == 0) ? 1'b0 : prod[sh_src[n]*8 + sh_sig[n]];
  endfunction

  function automatic logic [11:0] model_out();
    logic [11:0] r;
    for (int n = 0; n < 12; n++) begin
      logic s, p, h;
      s = model_sel(n); p = mprev[n];
      case (sh_mode[n])
        0: h = s;
        1: h = s & ~p;
        2: h = ~s & p;
        default: h = s ^ p;
      endcase
      if (sh_async[n] != 0) h = s;
      r[n] = h ^ sh_level[n] ^ pulse_exp[n];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    pulse_exp <= '0;
    if (!rst_n) mprev <= '0;
    else for (int n = 0; n < 12; n++) mprev[n] <= model_sel(n);
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(string req);
    logic [11:0] m;
    m = model_out();
    chk(req, {13'd0, pin_loc, pin_out, chan_out}, {13'd0, sh_loc, m[3:0] & sh_pen, m});
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; addr = 10'h3FC;
    if (a == 10'h0) pulse_exp = d[11:0];
    else if (a == 10'h4) sh_level = d[11:0];
    else if (a == 10'h8) begin sh_pen = d[3:0]; sh_loc = d[10:8]; end
    else if (a >= 10'h10) begin
      int n = (a - 16) / 4;
      sh_sig[n] = d[2:0]; sh_src[n] = d[21:16];
      sh_mode[n] = d[25:24]; sh_async[n] = d[28];
    end
    #1;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic step(); @(negedge clk); endtask

  function automatic logic [31:0] cw(int src, int sig, int mode, int asy);
    return (32'(asy) << 28) | (32'(mode) << 24) | (32'(src) << 16) | 32'(sig);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2718));
    for (int n = 0; n < 12; n++) begin sh_src[n]=0; sh_sig[n]=0; sh_mode[n]=0; sh_async[n]=0; end
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    // R1 reset state
    chk("R1 outputs", {17'd0, pin_loc, pin_out, chan_out}, 32'd0);
    rd(10'h0, d); chk("R1 pulse reg", d, 0);
    rd(10'h4, d); chk("R1 level reg", d, 0);
    rd(10'h8, d); chk("R1 route reg", d, 0);
    for (int n = 0; n < 12; n++) begin rd(10'(16 + 4*n), d); chk("R1 ctrl reg", d, 0); end

    // R2 field layout
    wr(10'h24, 32'hFFFF_FFFF);
    rd(10'h24, d); chk("R2 ctrl readback", d, 32'h133F_0007);
    wr(10'h24, 32'h0);
    rd(10'h24, d); chk("R2 ctrl clear", d, 0);

    // R3 source 0 stays low
    wr(10'h10, cw(0, 3, 0, 0));
    step(); prod = '1; #1;
    chk("R3 no source", 32'(chan_out[0]), 0);
    chk_all("R3 model");
    step(); prod = '0; #1;

    // R4 selection
    wr(10'h14, cw(37, 5, 0, 0));
    step(); prod[301] = 1; #1; chk("R4 select high", 32'(chan_out[1]), 1);
    step(); prod[301] = 0; #1; chk("R4 select low", 32'(chan_out[1]), 0);

    // R5 rising
    wr(10'h18, cw(2, 1, 1, 0));
    step(); prod[17] = 1; #1; chk("R5 rise pulse", 32'(chan_out[2]), 1);
    step(); #1; chk("R5 one cycle", 32'(chan_out[2]), 0);
    step(); prod[17] = 0; #1; chk("R5 fall ignored", 32'(chan_out[2]), 0);
    // R6 falling
    wr(10'h18, cw(2, 1, 2, 0));
    step(); prod[17] = 1; #1; chk("R6 rise ignored", 32'(chan_out[2]), 0);
    step(); prod[17] = 0; #1; chk("R6 fall pulse", 32'(chan_out[2]), 1);
    step(); #1; chk("R6 one cycle", 32'(chan_out[2]), 0);
    // R7 both
    wr(10'h18, cw(2, 1, 3, 0));
    step(); prod[17] = 1; #1; chk("R7 rise pulse", 32'(chan_out[2]), 1);
    step(); #1; chk("R7 gap", 32'(chan_out[2]), 0);
    step(); prod[17] = 0; #1; chk("R7 fall pulse", 32'(chan_out[2]), 1);
    step(); #1; chk("R7 one cycle", 32'(chan_out[2]), 0);
    // R8 direct
    wr(10'h18, cw(2, 1, 1, 1));
    step(); prod[17] = 1; #1; chk("R8 level", 32'(chan_out[2]), 1);
    step(); #1; chk("R8 held", 32'(chan_out[2]), 1);
    step(); #1; chk("R8 held2", 32'(chan_out[2]), 1);
    step(); prod[17] = 0; #1; chk("R8 low", 32'(chan_out[2]), 0);

    // R10 level
    wr(10'h4, 32'hFFFF_F801);
    rd(10'h4, d); chk("R10 readback", d, 32'h801);
    chk("R10 outputs", 32'(chan_out), 32'h801);
    // R12 xor of level and hardware
    wr(10'h4, 32'h4);
    step(); prod[17] = 1; #1; chk("R12 level cancels hw", 32'(chan_out[2]), 0);

    // R9 pulse, R12 pulse with level and hardware
    wr(10'h0, 32'h0000_00A4);
    chk("R9 pulse bits", 32'(chan_out & 12'h0A4), 32'h0A4);
    rd(10'h0, d); chk("R9 reads zero", d, 0);
    step(); #1; chk("R9 pulse gone", 32'(chan_out & 12'h0A0), 0);
    chk("R12 back to level^hw", 32'(chan_out[2]), 0);

    // R11 routing
    step(); prod[17] = 0;
    wr(10'h4, 32'hF);
    wr(10'h8, 32'hFFFF_F305);
    rd(10'h8, d); chk("R11 readback", d, 32'h305);
    chk("R11 pins", {28'd0, pin_out}, 32'h5);
    chk("R11 loc", 32'(pin_loc), 3);
    wr(10'h4, 32'h0);
    chk("R11 pins low", 32'(pin_out), 0);

    // R12 random mix
    for (int n = 0; n < 12; n++)
      wr(10'(16 + 4*n), cw($urandom_range(0, 63), $urandom_range(0, 7),
                           $urandom_range(0, 3), ($urandom_range(0, 3) == 0) ? 1 : 0));
    wr(10'h4, $urandom);
    wr(10'h8, {21'd0, 3'($urandom_range(0, 1)), 4'd0, 4'($urandom)});
    for (int c = 0; c < 400; c++) begin
      step();
      prod = {16{$urandom}} ^ (prod & {16{$urandom}});
      #1; chk_all("R12 random");
      if ($urandom_range(0, 9) == 0) begin
        wr(10'h0, $urandom); chk_all("R9 random pulse");
      end else if ($urandom_range(0, 19) == 0) begin
        wr(10'(16 + 4*$urandom_range(0, 11)), cw($urandom_range(0, 63),
           $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 1)));
        chk_all("R12 reconfig");
      end
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule